// File: doc/BRIEF.md
# Paged DMA Address and Count Engine

This block tracks the progress of one DMA channel whose upper address bits come from a separate page value. A load strobe programs a 16-bit base address, a 16-bit base count, an 8-bit page and three mode bits: channel width, autoinit and address direction. Each accepted step strobe stands for one finished bus transfer. On each one the engine moves its current address by one unit and decrements its current count. For every transfer it presents a 24-bit physical bus address.

The count is programmed as the number of transfers minus one. The run ends when the count passes from zero to all-ones. At that point the engine raises terminal count for one cycle. With autoinit set it reloads itself from the base values. With autoinit clear it masks itself and ignores further steps until the next load. The address wraps inside its page and never carries into the page value.

Top module: `paged_xfer_engine`

## Requirements
- R1: After reset the remaining count reads 0xFFFF, the physical address reads 0, terminal count is low and the channel is masked.
- R2: A load copies the base address and base count into the current registers and unmasks the channel. The values show one cycle after the load strobe. A load has priority over a step in the same cycle.
- R3: For a byte channel (word_mode=0) the physical address is page[7:0] in bits 23:16 and the current address in bits 15:0.
- R4: For a word channel (word_mode=1) the physical address is page[7:1] in bits 23:17, the current address in bits 16:1 and 0 in bit 0. Page bit 0 has no effect.
- R5: Each accepted step decrements the remaining count by one.
- R6: With count_down=0, each accepted step raises the current address by one.
- R7: With count_down=1, each accepted step lowers the current address by one.
- R8: The address wraps modulo 2^16 inside its page (0xFFFF up to 0x0000, 0x0000 down to 0xFFFF). The page bits of the physical address never change between loads.
- R9: A step taken while the count is 0x0000 raises tc for exactly the following cycle. A programmed count of N-1 therefore gives N transfers.
- R10: With autoinit=1, the terminating step reloads the current address and count from the base values, and the channel stays unmasked.
- R11: With autoinit=0, the terminating step leaves the count at 0xFFFF and sets masked.
- R12: Steps that arrive while the channel is masked change neither the count nor the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Program strobe for the base values and mode bits |
| base_addr | input | 16 | Base address, in byte or word units |
| base_count | input | 16 | Number of transfers minus one |
| page | input | 8 | Page value for the upper physical address bits |
| word_mode | input | 1 | 1 selects a 16-bit channel, 0 an 8-bit channel |
| autoinit | input | 1 | 1 reloads from the base values at terminal count |
| count_down | input | 1 | 1 makes the address go down on each transfer |
| step | input | 1 | One pulse per completed transfer |
| phys_addr | output | 24 | Physical bus address of the current transfer |
| tc | output | 1 | Terminal count, high for one cycle |
| remaining | output | 16 | Current count readback |
| masked | output | 1 | Channel masked; steps are ignored |

## Verification
Every stored result (current address, count, mask and tc) changes on the clock edge that samples the load or step strobe. The physical address follows combinationally from those registers. All results are therefore due one edge after the stimulus. The bench drives strobes on the falling edge and samples on the next falling edge, which puts each check half a cycle after the edge where the result was set. The check that tc has dropped is taken one cycle later again, which confirms that tc lasts a single cycle.

// File: rtl/paged_dma_pkg.sv
package paged_dma_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } addr_dir_e;

  typedef struct packed {
    logic      word_mode;
    logic      autoinit;
    addr_dir_e dir;
  } chan_mode_t;
endpackage

// File: rtl/pdma_count_unit.sv
module pdma_count_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] base_count,
  input  logic             autoinit,
  input  logic             step,
  output logic [CNT_W-1:0] cur_count,
  output logic             advance,
  output logic             wrap_evt,
  output logic             tc,
  output logic             masked
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] base_q;

  function automatic logic [CNT_W-1:0] dec_count(input logic [CNT_W-1:0] c);
    return c - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  assign advance  = step && !masked && !load;
  assign wrap_evt = advance && (cur_count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      cur_count <= ALL_ONES;
      tc        <= 1'b0;
      masked    <= 1'b1;
    end else if (load) begin
      base_q    <= base_count;
      cur_count <= base_count;
      tc        <= 1'b0;
      masked    <= 1'b0;
    end else begin
      tc <= wrap_evt;
      if (advance) begin
        if (wrap_evt && autoinit) cur_count <= base_q;
        else                      cur_count <= dec_count(cur_count);
        if (wrap_evt && !autoinit) masked <= 1'b1;
      end
    end
  end

  AST_COUNT_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wrap_evt) |=> (cur_count == $past(cur_count) - 1'b1)); // R5
  AST_TC_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc) |-> ($past(cur_count) == '0)); // R9
  AST_STOP_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !autoinit) |=> (masked && cur_count == ALL_ONES)); // R11
  AST_MASK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (masked && !load) |=> $stable(cur_count)); // R12
endmodule

// File: rtl/pdma_addr_unit.sv
module pdma_addr_unit
  import paged_dma_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_addr,
  input  addr_dir_e         dir,
  input  logic              advance,
  input  logic              reload,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [ADDR_W-1:0] base_q;

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input addr_dir_e d);
    return (d == DIR_DOWN) ? a - 1'b1 : a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      cur_addr <= '0;
    end else if (load) begin
      base_q   <= base_addr;
      cur_addr <= base_addr;
    end else if (advance) begin
      cur_addr <= reload ? base_q : next_addr(cur_addr, dir);
    end
  end

  AST_ADDR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !reload && !load && dir == DIR_UP) |=> (cur_addr == $past(cur_addr) + 1'b1)); // R6
  AST_ADDR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !reload && !load && dir == DIR_DOWN) |=> (cur_addr == $past(cur_addr) - 1'b1)); // R7
  AST_ADDR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && reload && !load) |=> (cur_addr == base_q)); // R10
endmodule

// File: rtl/paged_xfer_engine.sv
module paged_xfer_engine
  import paged_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [ADDR_W-1:0]        base_addr,
  input  logic [CNT_W-1:0]         base_count,
  input  logic [PAGE_W-1:0]        page,
  input  logic                     word_mode,
  input  logic                     autoinit,
  input  logic                     count_down,
  input  logic                     step,
  output logic [PAGE_W+ADDR_W-1:0] phys_addr,
  output logic                     tc,
  output logic [CNT_W-1:0]         remaining,
  output logic                     masked
);
  localparam int PHYS_W = PAGE_W + ADDR_W;

  chan_mode_t        mode_q;
  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] cur_addr;
  logic              advance;
  logic              wrap_evt;
  logic              reload;

  function automatic logic [PHYS_W-1:0] map_phys(input logic [PAGE_W-1:0] pg,
                                                 input logic [ADDR_W-1:0] a,
                                                 input logic              wide);
    if (wide) return {pg[PAGE_W-1:1], a, 1'b0};
    else      return {pg, a};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      mode_q <= '{word_mode: 1'b0, autoinit: 1'b0, dir: DIR_UP};
    end else if (load) begin
      page_q <= page;
      mode_q <= '{word_mode: word_mode, autoinit: autoinit,
                  dir: (count_down ? DIR_DOWN : DIR_UP)};
    end
  end

  assign reload = wrap_evt && mode_q.autoinit;

  pdma_count_unit #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .base_count (base_count),
    .autoinit   (mode_q.autoinit),
    .step       (step),
    .cur_count  (remaining),
    .advance    (advance),
    .wrap_evt   (wrap_evt),
    .tc         (tc),
    .masked     (masked)
  );

  pdma_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .base_addr (base_addr),
    .dir       (mode_q.dir),
    .advance   (advance),
    .reload    (reload),
    .cur_addr  (cur_addr)
  );

  assign phys_addr = map_phys(page_q, cur_addr, mode_q.word_mode);

  AST_PAGE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(phys_addr[PHYS_W-1:ADDR_W+1])); // R8
  AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && mode_q.word_mode) |=> (phys_addr[0] == 1'b0)); // R4
  AST_LOAD_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!masked && remaining == $past(base_count))); // R2
endmodule

// File: tb/sim_paged_xfer_engine.sv
module sim_paged_xfer_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [15:0] base_addr = '0;
  logic [15:0] base_count = '0;
  logic [7:0]  page = '0;
  logic        word_mode = 1'b0;
  logic        autoinit = 1'b0;
  logic        count_down = 1'b0;
  logic        step = 1'b0;
  logic [23:0] phys_addr;
  logic        tc;
  logic [15:0] remaining;
  logic        masked;

  int checks = 0;
  int bad = 0;

  always #4 clk = ~clk;

  paged_xfer_engine u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .base_addr(base_addr),
    .base_count(base_count), .page(page), .word_mode(word_mode),
    .autoinit(autoinit), .count_down(count_down), .step(step),
    .phys_addr(phys_addr), .tc(tc), .remaining(remaining), .masked(masked)
  );

  // Fields: page[48:41] addr[40:25] word[24] expected physical address[23:0]
  localparam logic [48:0] VEC [5] = '{
    {8'h05, 16'h1234, 1'b0, 24'h051234},
    {8'h05, 16'h1234, 1'b1, 24'h042468},
    {8'hFF, 16'hFFFF, 1'b1, 24'hFFFFFE},
    {8'hA3, 16'h8001, 1'b0, 24'hA38001},
    {8'h00, 16'h8000, 1'b1, 24'h010000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] a, input logic [15:0] c, input logic [7:0] p,
                         input logic w, input logic ai, input logic dn);
    base_addr = a; base_count = c; page = p;
    word_mode = w; autoinit = ai; count_down = dn;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_step();
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  initial begin
    #1_000_000;
    bad++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 remaining", remaining, 32'hFFFF);
    chk("R1 phys", phys_addr, 0);
    chk("R1 tc", tc, 0);
    chk("R1 masked", masked, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 / R4 address mapping table
    for (int i = 0; i < 5; i++) begin
      do_load(VEC[i][40:25], 16'h0010, VEC[i][48:41], VEC[i][24], 1'b0, 1'b0);
      chk(VEC[i][24] ? "R4 word map" : "R3 byte map", phys_addr, VEC[i][23:0]);
    end

    // R2, R5, R6, R9, R11, R12: three transfers, no autoinit
    do_load(16'h1234, 16'h0002, 8'h05, 1'b0, 1'b0, 1'b0);
    chk("R2 remaining", remaining, 32'h2);
    chk("R2 masked", masked, 0);
    do_step();
    chk("R5 remaining", remaining, 32'h1);
    chk("R6 phys", phys_addr, 32'h051235);
    do_step();
    chk("R5 remaining", remaining, 32'h0);
    chk("R9 no early tc", tc, 0);
    do_step();
    chk("R9 tc", tc, 1);
    chk("R11 remaining", remaining, 32'hFFFF);
    chk("R11 masked", masked, 1);
    chk("R6 phys", phys_addr, 32'h051237);
    do_step();
    chk("R9 tc drop", tc, 0);
    chk("R12 remaining", remaining, 32'hFFFF);
    chk("R12 phys", phys_addr, 32'h051237);

    // R2 load wins over a step in the same cycle
    step = 1'b1;
    do_load(16'h0200, 16'h0007, 8'h01, 1'b0, 1'b0, 1'b0);
    step = 1'b0;
    chk("R2 load priority", remaining, 32'h7);

    // R8 upward wrap in page
    do_load(16'hFFFF, 16'h0005, 8'h12, 1'b0, 1'b0, 1'b0);
    do_step();
    chk("R8 up wrap", phys_addr, 32'h120000);

    // R7 / R8 downward wrap on a word channel; page bit 0 dropped
    do_load(16'h0000, 16'h0005, 8'h33, 1'b1, 1'b0, 1'b1);
    chk("R4 word base", phys_addr, 32'h320000);
    do_step();
    chk("R7 down wrap", phys_addr, 32'h33FFFE);
    do_step();
    chk("R7 down", phys_addr, 32'h33FFFC);

    // R10 autoinit reload
    do_load(16'h0100, 16'h0001, 8'h40, 1'b0, 1'b1, 1'b0);
    do_step();
    chk("R10 pre remaining", remaining, 32'h0);
    do_step();
    chk("R10 tc", tc, 1);
    chk("R10 remaining", remaining, 32'h1);
    chk("R10 phys", phys_addr, 32'h400100);
    chk("R10 masked", masked, 0);
    do_step();
    chk("R10 tc drop", tc, 0);
    chk("R10 continue", remaining, 32'h0);

    // R9 single transfer with count 0
    do_load(16'h0050, 16'h0000, 8'h02, 1'b0, 1'b0, 1'b0);
    do_step();
    chk("R9 single tc", tc, 1);
    chk("R11 single masked", masked, 1);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule